// File: doc/BRIEF.md
# Keyed Code-Space Remap Controller

This block is a small system-control unit on an 8-bit register bus. Software writes a staged control register that holds three bits: one that places RAM in the code space, one that moves the interrupt and vector-call tables into RAM, and one that disables a reset source. None of these bits acts at once. A second register is write-only and serves as a key. Writing a recognised code to it copies the matching staged bits into active state on that clock edge. One code does not copy any bit. It produces a single-cycle strobe that an external flag-clear circuit uses.

The block also decodes each 16-bit code-fetch address. It combines the active state with a serial-boot-mode input and returns two things: a physical address, and a select that says whether RAM or program ROM answers the fetch. The decode is purely combinational, so the select and the address follow the fetch address within the same cycle.

Top module: `keyed_remap_ctrl`

## Requirements
- R1: After reset, the staged control register reads 0x00. The map, vector and reset-disable active outputs are 0 and the flag-clear strobe is 0.
- R2: With `reg_sel`=0, a write stores `reg_wdata[2:0]`. Bit 2 is vector relocation, bit 1 is RAM code mapping and bit 0 is reset disable. A read with `reg_sel`=0 returns these bits in the same positions, and bits 7..3 read as 0.
- R3: The key register (`reg_sel`=1) always reads 0x00.
- R4: A key write of 0xD4 copies staged bits 2 and 1 to `vec_on` and `map_on` on that clock edge. `rst_dis_on` is not changed.
- R5: A key write of 0xB2 copies staged bit 0 to `rst_dis_on` on that clock edge. `map_on` and `vec_on` are not changed.
- R6: A key write of 0x71 drives `fclr_pulse` high for exactly the one cycle after that edge. No active bit changes.
- R7: A key write of any other value leaves every active output unchanged and gives no strobe.
- R8: A staged RAM-mapping bit that has not yet been committed has no effect on the fetch decode.
- R9: When `map_on`=1, fetch addresses 0x0040..0x083F give `ram_sel`=1 with an unchanged address. Addresses just outside that range (0x003F and 0x0840) give `ram_sel`=0.
- R10: When both `vec_on` and `map_on` are 1, fetches in 0xFFA0..0xFFBF and 0xFFC8..0xFFFD give `phys_addr` = 0x01 followed by the low byte of the fetch address, with `ram_sel`=1. The gap 0xFFC0..0xFFC7 is not relocated. If `map_on`=0, no relocation happens.
- R11: Fetches at 0xFFFE and 0xFFFF are never relocated and always give `ram_sel`=0.
- R12: While `boot_serial`=1, the range 0x0040..0x083F gives `ram_sel`=1 whatever the value of `map_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_sel | input | 1 | Register select: 0 selects the staged control register, 1 selects the key register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| boot_serial | input | 1 | Serial boot mode; forces the RAM code window |
| fetch_addr | input | 16 | Code-space fetch address |
| phys_addr | output | 16 | Remapped physical address |
| ram_sel | output | 1 | 1 = RAM answers the fetch, 0 = ROM answers it |
| map_on | output | 1 | Active RAM code mapping |
| vec_on | output | 1 | Active vector relocation |
| rst_dis_on | output | 1 | Active reset disable |
| fclr_pulse | output | 1 | One-cycle flag-clear commit strobe |

## Verification
The decode is tested at each edge of the RAM window (0x003F, 0x0040, 0x083F, 0x0840). This shows whether an off-by-one error exists at the window limits. The vector ends 0xFFA0, 0xFFBF, 0xFFC0, 0xFFC8, 0xFFFD, 0xFFFE and 0xFFFF are also tested. These separate the two relocated tables from the unrelocated gap between them and from the protected reset vector. Key writes use each of the three codes and a wrong code, with the staged bits set to different patterns, so that a commit of the wrong field shows up as a wrong active output. The serial-boot input is raised while mapping is off. This shows whether the window is forced by the pin or by the committed bit.

// File: rtl/keyed_remap_ctrl.sv
module keyed_remap_ctrl #(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [7:0]  KEY_MAP   = 8'hD4,
  parameter logic [7:0]  KEY_RST   = 8'hB2,
  parameter logic [7:0]  KEY_FCLR  = 8'h71,
  parameter logic [15:0] WIN_LO    = 16'h0040,
  parameter logic [15:0] WIN_HI    = 16'h083F,
  parameter logic [7:0]  VEC_SRC   = 8'hFF,
  parameter logic [7:0]  VEC_DST   = 8'h01,
  parameter logic [7:0]  TBL_A_LO  = 8'hA0,
  parameter logic [7:0]  TBL_A_HI  = 8'hBF,
  parameter logic [7:0]  TBL_B_LO  = 8'hC8,
  parameter logic [7:0]  TBL_B_HI  = 8'hFD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          boot_serial,
  input  logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] phys_addr,
  output logic          ram_sel,
  output logic          map_on,
  output logic          vec_on,
  output logic          rst_dis_on,
  output logic          fclr_pulse
);

  localparam int SW = 3;

  logic [SW-1:0] stage;
  logic          key_wr, ctl_wr;
  logic          in_win, in_vec;
  logic [7:0]    lo_byte;

  assign ctl_wr = reg_wr && !reg_sel;
  assign key_wr = reg_wr && reg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage      <= '0;
      map_on     <= 1'b0;
      vec_on     <= 1'b0;
      rst_dis_on <= 1'b0;
      fclr_pulse <= 1'b0;
    end else begin
      fclr_pulse <= key_wr && (reg_wdata[7:0] == KEY_FCLR);
      if (ctl_wr) stage <= reg_wdata[SW-1:0];
      if (key_wr && reg_wdata[7:0] == KEY_MAP) begin
        map_on <= stage[1];
        vec_on <= stage[2];
      end
      if (key_wr && reg_wdata[7:0] == KEY_RST)
        rst_dis_on <= stage[0];
    end
  end

  assign reg_rdata = reg_sel ? '0 : {{(DW-SW){1'b0}}, stage};

  assign lo_byte = fetch_addr[7:0];
  assign in_win  = (fetch_addr >= AW'(WIN_LO)) && (fetch_addr <= AW'(WIN_HI));
  assign in_vec  = map_on && vec_on && (fetch_addr[AW-1:8] == (AW-8)'(VEC_SRC)) &&
                   (((lo_byte >= TBL_A_LO) && (lo_byte <= TBL_A_HI)) ||
                    ((lo_byte >= TBL_B_LO) && (lo_byte <= TBL_B_HI)));

  always_comb begin
    phys_addr = fetch_addr;
    ram_sel   = 1'b0;
    if (in_vec) begin
      phys_addr = {(AW-8)'(VEC_DST), lo_byte};
      ram_sel   = 1'b1;
    end else if (in_win && (map_on || boot_serial)) begin
      ram_sel   = 1'b1;
    end
  end

  assert_commit_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && reg_wdata[7:0] == KEY_MAP) |=>
      (map_on == $past(stage[1]) && vec_on == $past(stage[2]) && $stable(rst_dis_on)));

  assert_strobe_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fclr_pulse |-> $past(key_wr && reg_wdata[7:0] == KEY_FCLR));

  assert_bad_key_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && reg_wdata[7:0] != KEY_MAP && reg_wdata[7:0] != KEY_RST &&
     reg_wdata[7:0] != KEY_FCLR) |=>
      ($stable(map_on) && $stable(vec_on) && $stable(rst_dis_on) && !fclr_pulse));

  assert_reset_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (&fetch_addr[AW-1:1]) |-> (!ram_sel && phys_addr == fetch_addr));

  assert_boot_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_serial && fetch_addr >= AW'(WIN_LO) && fetch_addr <= AW'(WIN_HI)) |-> ram_sel);

endmodule

// File: tb/keyed_remap_ctrl_test.sv
module keyed_remap_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0, boot_serial = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [15:0] fetch_addr = 16'h0000;
  logic [7:0]  reg_rdata;
  logic [15:0] phys_addr;
  logic        ram_sel, map_on, vec_on, rst_dis_on, fclr_pulse;

  int checks = 0, errors = 0;
  bit done = 0;

  bit [2:0] m_stage = 0;
  bit m_map = 0, m_vec = 0, m_rst = 0, m_pulse = 0;

  always #2.5 clk = ~clk;

  keyed_remap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .boot_serial(boot_serial),
    .fetch_addr(fetch_addr), .phys_addr(phys_addr), .ram_sel(ram_sel),
    .map_on(map_on), .vec_on(vec_on), .rst_dis_on(rst_dis_on), .fclr_pulse(fclr_pulse)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int ex_phys;
    bit ex_ram;
    int lo;
    lo = fetch_addr & 16'hFF;
    ex_phys = fetch_addr;
    ex_ram  = 0;
    if (m_map && m_vec && fetch_addr[15:8] == 8'hFF &&
        ((lo >= 'hA0 && lo <= 'hBF) || (lo >= 'hC8 && lo <= 'hFD))) begin
      ex_phys = 'h0100 + lo;
      ex_ram  = 1;
    end else if (fetch_addr >= 'h0040 && fetch_addr <= 'h083F && (m_map || boot_serial))
      ex_ram = 1;
    chk(tag, "phys_addr", phys_addr, ex_phys);
    chk(tag, "ram_sel", ram_sel, ex_ram);
    chk(tag, "reg_rdata", reg_rdata, reg_sel ? 0 : m_stage);
    chk(tag, "map_on", map_on, m_map);
    chk(tag, "vec_on", vec_on, m_vec);
    chk(tag, "rst_dis_on", rst_dis_on, m_rst);
    chk(tag, "fclr_pulse", fclr_pulse, m_pulse);
  endtask

  task automatic step(input string tag, input bit wr, input bit sel, input int wd,
                      input bit boot, input int addr);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd[7:0];
    boot_serial = boot; fetch_addr = addr[15:0];
    #1 compare(tag);
    @(posedge clk);
    m_pulse = wr && sel && wd[7:0] == 8'h71;
    if (wr && !sel) m_stage = wd[2:0];
    if (wr && sel && wd[7:0] == 8'hD4) begin m_map = m_stage[1]; m_vec = m_stage[2]; end
    if (wr && sel && wd[7:0] == 8'hB2) m_rst = m_stage[0];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 'h0040);
    step("R2", 1, 0, 'hFF, 0, 'h0040);
    step("R2", 0, 0, 0, 0, 'h0040);
    step("R3", 0, 1, 0, 0, 'h0040);
    step("R8", 1, 0, 'h02, 0, 'h0040);
    step("R8", 0, 0, 0, 0, 'h0040);
    step("R7", 1, 1, 'h55, 0, 'h0040);
    step("R7", 1, 1, 'hD5, 0, 'h0040);
    step("R7", 0, 0, 0, 0, 'h0040);
    step("R2", 1, 0, 'h06, 0, 'h0000);
    step("R4", 1, 1, 'hD4, 0, 'h0000);
    step("R4", 0, 0, 0, 0, 'h003F);
    step("R9", 0, 0, 0, 0, 'h0040);
    step("R9", 0, 0, 0, 0, 'h083F);
    step("R9", 0, 0, 0, 0, 'h0840);
    step("R10", 0, 0, 0, 0, 'hFFA0);
    step("R10", 0, 0, 0, 0, 'hFFBF);
    step("R10", 0, 0, 0, 0, 'hFFC0);
    step("R10", 0, 0, 0, 0, 'hFFC7);
    step("R10", 0, 0, 0, 0, 'hFFC8);
    step("R10", 0, 0, 0, 0, 'hFFFD);
    step("R10", 0, 0, 0, 0, 'hFF9F);
    step("R11", 0, 0, 0, 0, 'hFFFE);
    step("R11", 0, 0, 0, 0, 'hFFFF);
    step("R5", 1, 0, 'h01, 0, 'h0000);
    step("R5", 1, 1, 'hB2, 0, 'h0000);
    step("R5", 1, 1, 'hD4, 0, 'hFFA0);
    step("R5", 0, 0, 0, 0, 'h0100);
    step("R6", 1, 1, 'h71, 0, 'h0000);
    step("R6", 0, 0, 0, 0, 'h0000);
    step("R6", 0, 0, 0, 0, 'h0000);
    step("R7", 1, 1, 'h70, 0, 'h0000);
    step("R7", 0, 0, 0, 0, 'h0000);
    step("R10", 1, 0, 'h04, 0, 'h0000);
    step("R10", 1, 1, 'hD4, 0, 'hFFA0);
    step("R10", 0, 0, 0, 0, 'hFFA0);
    step("R10", 0, 0, 0, 0, 'hFFD0);
    step("R12", 0, 0, 0, 1, 'h0040);
    step("R12", 0, 0, 0, 1, 'h083F);
    step("R12", 0, 0, 0, 1, 'h0840);
    step("R12", 0, 0, 0, 1, 'h003F);
    step("R11", 0, 0, 0, 1, 'hFFFF);
    step("R12", 0, 0, 0, 0, 'h0040);
    step("R5", 1, 0, 'h00, 0, 'h0000);
    step("R5", 1, 1, 'hB2, 0, 'h0000);
    step("R5", 0, 0, 0, 0, 'h0000);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule